// File: doc/BRIEF.md
# Parallel symmetric line convolver

This block filters image rows with a one-dimensional fixed-point kernel that has an odd number of taps and is either mirror-symmetric (even) or mirror-antisymmetric (odd). Each input beat carries four adjacent pixels, and each output beat carries four adjacent filtered pixels. The four output lanes are computed side by side. For each lane, every pair of samples at equal distance from the centre is added (even kernels) or subtracted (odd kernels) before it meets its one shared coefficient. A kernel of T taps therefore needs (T+1)/2 multipliers per lane instead of T.

Before a row is streamed, software writes the coefficients, the row length and the symmetry mode through a small write port. Pixels beyond either end of the row take the value of the nearest edge pixel. When the last input beat of a row has been taken, the engine inserts its own padding beats to drain the pipeline. No sample from one row reaches the outputs of the next row. Input and output use valid/ready handshakes, and the final output beat of a row is flagged.

Top module: `line_conv`

## Requirements
- R1: Each 16-bit input pixel is shifted right by one bit before use, so only pixel bits 15:1 affect any output. Lane l of input beat b (bits 16l+15:16l) is pixel 4b+l of the row.
- R2: With the mode bit at 0 (even), output pixel n equals c0*x[n] + sum over k=1..H of ck*(x[n+k]+x[n-k]), where x is the shifted pixel and H=(TAPS-1)/2.
- R3: With the mode bit at 1 (odd), output pixel n equals c0*x[n] + sum over k=1..H of ck*(x[n+k]-x[n-k]).
- R4: Coefficients are signed Q1.15. Each product is rounded on its own as (p + 2^14) >>> 15. The rounded terms are summed and wrapped to 16 bits, with no saturation.
- R5: Lane l of output beat b (bits 16l+15:16l) is output pixel 4b+l, and all four lanes are valid in the same beat.
- R6: Sample positions below 0 read pixel 0 of the row, and positions at or above the row length read the last pixel.
- R7: Configuration writes use address k (0..H) for coefficient ck and address H+1 for the row length in pixels. In a row-length write, bits 1:0 are ignored, and a write whose length field is zero is ignored. Address H+2 bit 0 holds the mode.
- R8: A configuration write is ignored while a row is being taken in or while any of its outputs is still in the pipeline.
- R9: Each row produces exactly row_length/4 output beats. The end-of-row flag is high on the last of them and low on all the others.
- R10: In the cycle after the last input beat of a row is accepted, in_ready_o is low while the engine drains the pipeline. The next row's outputs depend only on that row's pixels.
- R11: While out_valid_o is high and out_ready_i is low, the output data and flag hold and in_ready_o is low.
- R12: After reset, out_valid_o is low, in_ready_o is high, all coefficients are zero, the mode is even and the row length is DEF_ROW_LEN.
- R13: With no back-pressure, output beat b becomes valid on the second rising edge after the edge that accepts input beat b+NB, where NB=ceil(H/4). NB is 1 for the default nine-tap kernel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| in_data_i | input | LANES*PIX_W | Four adjacent pixels, lane 0 lowest |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | LANES*16 | Four adjacent filtered pixels, lane 0 lowest |
| out_last_o | output | 1 | Last output beat of the row |

## Verification
The hardest condition to reach is a configuration write that lands while the pipeline still holds a row. Writes are normally issued between rows, so no ordinary traffic produces one. The stimulus therefore forces a coefficient write two cycles into a row, then runs that row and a second row against the unchanged model. Single-beat rows and rows whose length has its two low bits set exercise both edges of the replication logic, and stalling rows send random-looking gaps on both handshakes.

// File: rtl/lc_pkg.sv
package lc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned COEF_W = 16;
  localparam int unsigned FRAC_W = 15;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/lc_cfg.sv
module lc_cfg
  import lc_pkg::*;
#(
  parameter int unsigned TAPS        = 9,
  parameter int unsigned LANES       = 4,
  parameter int unsigned CFG_AW      = 3,
  parameter int unsigned DEF_ROW_LEN = 64,
  localparam int unsigned HT = (TAPS - 1) / 2,
  localparam int unsigned LB = $clog2(LANES),
  localparam int unsigned BW = DATA_W - LB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CFG_AW-1:0]    addr_i,
  input  word_t                wdata_i,
  input  logic                 lock_i,
  output logic [HT:0][COEF_W-1:0] coef_o,
  output logic [BW-1:0]        row_beats_o,
  output logic                 odd_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CFG_AW-1:0] A_LEN  = CFG_AW'(HT + 1);
  localparam logic [CFG_AW-1:0] A_MODE = CFG_AW'(HT + 2);

  logic wr;
  assign wr = we_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_o      <= '0;
      row_beats_o <= BW'(DEF_ROW_LEN >> LB);
      odd_o       <= 1'b0;
    end else if (wr) begin
      for (int k = 0; k <= int'(HT); k++) begin
        if (addr_i == CFG_AW'(k)) coef_o[k] <= wdata_i;
      end
      if (addr_i == A_LEN && wdata_i[DATA_W-1:LB] != '0) row_beats_o <= wdata_i[DATA_W-1:LB];
      if (addr_i == A_MODE) odd_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/lc_window.sv
module lc_window #(
  parameter int unsigned LANES = 4,
  parameter int unsigned SMP_W = 15,
  parameter int unsigned NB    = 1,
  parameter int unsigned BW    = 14,
  localparam int unsigned WIN  = (2 * NB + 1) * LANES,
  localparam int unsigned CW   = BW + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             adv_i,
  input  logic                             in_valid_i,
  input  logic [LANES-1:0][SMP_W-1:0]      in_smp_i,
  input  logic [BW-1:0]                    row_beats_i,
  output logic                             in_ready_o,
  output logic [WIN-1:0][SMP_W-1:0]        win_o,
  output logic                             va_o,
  output logic                             la_o,
  output logic                             row_act_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW-1:0] idx_q, cur_idx, total;
  logic [SMP_W-1:0] last_pix_q;
  logic in_phase, in_fire, flush_shift, shift, first;
  logic [LANES-1:0][SMP_W-1:0] new_beat;

  assign total       = {1'b0, row_beats_i} + CW'(NB);
  assign cur_idx     = row_act_o ? idx_q : '0;
  assign in_phase    = !row_act_o || (idx_q < {1'b0, row_beats_i});
  assign in_ready_o  = adv_i && in_phase;
  assign in_fire     = in_valid_i && in_ready_o;
  assign flush_shift = adv_i && row_act_o && !in_phase;
  assign shift       = in_fire || flush_shift;
  assign first       = in_fire && !row_act_o;

  // flush beats carry the row's last pixel on every lane
  always_comb begin
    for (int l = 0; l < int'(LANES); l++)
      new_beat[l] = in_fire ? in_smp_i[l] : last_pix_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_o      <= '0;
      idx_q      <= '0;
      row_act_o  <= 1'b0;
      last_pix_q <= '0;
      va_o       <= 1'b0;
      la_o       <= 1'b0;
    end else begin
      if (shift) begin
        for (int i = 0; i < int'(WIN - LANES); i++)
          win_o[i] <= first ? in_smp_i[0] : win_o[i+LANES];
        for (int l = 0; l < int'(LANES); l++)
          win_o[WIN-LANES+l] <= new_beat[l];
        idx_q     <= cur_idx + 1'b1;
        row_act_o <= (cur_idx + 1'b1) != total;
      end
      if (in_fire) last_pix_q <= in_smp_i[LANES-1];
      if (adv_i) begin
        va_o <= shift && (cur_idx >= CW'(NB));
        la_o <= shift && (cur_idx == total - 1'b1);
      end
    end
  end
endmodule

// File: rtl/lc_preadd.sv
module lc_preadd #(
  parameter int unsigned LANES = 4,
  parameter int unsigned SMP_W = 15,
  parameter int unsigned HT    = 4,
  parameter int unsigned NB    = 1,
  localparam int unsigned WIN   = (2 * NB + 1) * LANES,
  localparam int unsigned CTR   = NB * LANES,
  localparam int unsigned PRE_W = SMP_W + 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                adv_i,
  input  logic                                odd_i,
  input  logic [WIN-1:0][SMP_W-1:0]           win_i,
  input  logic                                va_i,
  input  logic                                la_i,
  output logic [LANES-1:0][HT:0][PRE_W-1:0]   pre_o,
  output logic                                vb_o,
  output logic                                lb_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LANES-1:0][HT:0][PRE_W-1:0] pre_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign pre_d[l][0] = PRE_W'(win_i[CTR+l]);
    for (genvar k = 1; k <= HT; k++) begin : g_pair
      logic [PRE_W-1:0] hi, lo;
      assign hi = PRE_W'(win_i[CTR+l+k]);
      assign lo = PRE_W'(win_i[CTR+l-k]);
      assign pre_d[l][k] = odd_i ? (hi - lo) : (hi + lo);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_o <= '0;
      vb_o  <= 1'b0;
      lb_o  <= 1'b0;
    end else if (adv_i) begin
      vb_o <= va_i;
      lb_o <= la_i;
      if (va_i) pre_o <= pre_d;
    end
  end
endmodule

// File: rtl/lc_mac.sv
module lc_mac
  import lc_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned HT    = 4,
  parameter int unsigned PRE_W = 17,
  localparam int unsigned PROD_W = PRE_W + COEF_W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               adv_i,
  input  logic [LANES-1:0][HT:0][PRE_W-1:0]  pre_i,
  input  logic [HT:0][COEF_W-1:0]            coef_i,
  input  logic                               vb_i,
  input  logic                               lb_i,
  output logic [LANES-1:0][DATA_W-1:0]       out_o,
  output logic                               out_valid_o,
  output logic                               out_last_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic signed [PROD_W-1:0] RND_BIAS = PROD_W'(1) <<< (FRAC_W - 1);

  logic [LANES-1:0][HT:0][DATA_W-1:0] term;
  logic [LANES-1:0][DATA_W-1:0] acc;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k <= HT; k++) begin : g_tap
      logic signed [PROD_W-1:0] prod;
      assign prod = $signed(pre_i[l][k]) * $signed(coef_i[k]);
      assign term[l][k] = DATA_W'((prod + RND_BIAS) >>> FRAC_W);
    end
    // wraps modulo 2^16 by design
    always_comb begin
      acc[l] = '0;
      for (int k = 0; k <= int'(HT); k++) acc[l] = acc[l] + term[l][k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o       <= '0;
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end else if (adv_i) begin
      out_valid_o <= vb_i;
      out_last_o  <= lb_i;
      if (vb_i) out_o <= acc;
    end
  end
endmodule

// File: rtl/line_conv.sv
module line_conv
  import lc_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned PIX_W       = 16,
  parameter int unsigned TAPS        = 9,
  parameter int unsigned DEF_ROW_LEN = 64,
  parameter int unsigned CFG_AW      = $clog2((TAPS - 1) / 2 + 3)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [CFG_AW-1:0]         cfg_addr_i,
  input  logic [15:0]               cfg_wdata_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [LANES*PIX_W-1:0]    in_data_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [LANES*16-1:0]       out_data_o,
  output logic                      out_last_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned HT    = (TAPS - 1) / 2;
  localparam int unsigned NB    = (HT + LANES - 1) / LANES;
  localparam int unsigned SMP_W = PIX_W - 1;
  localparam int unsigned PRE_W = SMP_W + 2;
  localparam int unsigned LB    = $clog2(LANES);
  localparam int unsigned BW    = DATA_W - LB;
  localparam int unsigned WIN   = (2 * NB + 1) * LANES;

  logic [HT:0][COEF_W-1:0] coef;
  logic [BW-1:0] row_beats;
  logic odd, adv, busy, row_act, va, la, vb, lb;
  logic [LANES-1:0][SMP_W-1:0] in_smp;
  logic [LANES-1:0] unused_lsb;
  logic [WIN-1:0][SMP_W-1:0] win;
  logic [LANES-1:0][HT:0][PRE_W-1:0] pre;
  logic [LANES-1:0][DATA_W-1:0] out_lanes;

  for (genvar l = 0; l < LANES; l++) begin : g_in
    assign in_smp[l]     = in_data_i[l*PIX_W+1 +: SMP_W];
    assign unused_lsb[l] = in_data_i[l*PIX_W];
  end

  assign adv        = !out_valid_o || out_ready_i;
  assign busy       = row_act || va || vb || out_valid_o;
  assign out_data_o = out_lanes;

  lc_cfg #(
    .TAPS(TAPS), .LANES(LANES), .CFG_AW(CFG_AW), .DEF_ROW_LEN(DEF_ROW_LEN)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .lock_i(busy), .coef_o(coef),
    .row_beats_o(row_beats), .odd_o(odd)
  );

  lc_window #(
    .LANES(LANES), .SMP_W(SMP_W), .NB(NB), .BW(BW)
  ) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .in_valid_i(in_valid_i),
    .in_smp_i(in_smp), .row_beats_i(row_beats), .in_ready_o(in_ready_o),
    .win_o(win), .va_o(va), .la_o(la), .row_act_o(row_act)
  );

  lc_preadd #(
    .LANES(LANES), .SMP_W(SMP_W), .HT(HT), .NB(NB)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .odd_i(odd), .win_i(win),
    .va_i(va), .la_i(la), .pre_o(pre), .vb_o(vb), .lb_o(lb)
  );

  lc_mac #(
    .LANES(LANES), .HT(HT), .PRE_W(PRE_W)
  ) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .pre_i(pre), .coef_i(coef),
    .vb_i(vb), .lb_i(lb), .out_o(out_lanes), .out_valid_o(out_valid_o),
    .out_last_o(out_last_o)
  );
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int unsigned LANES = 4,
  parameter int unsigned TAPS  = 9,
  localparam int unsigned HT = (TAPS - 1) / 2,
  localparam int unsigned BW = 16 - $clog2(LANES)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cfg_we_i,
  input logic                   busy_i,
  input logic [(HT+1)*16-1:0]   coef_i,
  input logic [BW-1:0]          row_beats_i,
  input logic                   odd_i,
  input logic                   in_ready_i,
  input logic                   out_valid_i,
  input logic                   out_ready_i,
  input logic                   out_last_i,
  input logic [LANES*16-1:0]    out_data_i
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [BW:0] ocnt;
  logic ofire;
  assign ofire = out_valid_i && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ocnt <= '0;
    else if (ofire) ocnt <= out_last_i ? '0 : ocnt + 1'b1;
  end

  p_last_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_i |-> out_valid_i);

  p_beat_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofire && out_last_i) |-> (ocnt + 1'b1) == {1'b0, row_beats_i});

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_data_i) && $stable(out_last_i)));

  p_stall_in_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |-> !in_ready_i);

  p_cfg_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && busy_i) |=> ($stable(coef_i) && $stable(row_beats_i) && $stable(odd_i)));

  p_len_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_beats_i != '0);
endmodule

bind line_conv lc_checker #(.LANES(LANES), .TAPS(TAPS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .busy_i(busy),
  .coef_i(coef), .row_beats_i(row_beats), .odd_i(odd), .in_ready_i(in_ready_o),
  .out_valid_i(out_valid_o), .out_ready_i(out_ready_i), .out_last_i(out_last_o),
  .out_data_i(out_data_o)
);

// File: tb/tb_line_conv.sv
module tb_line_conv;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 0;
  logic rst_ni = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic in_valid = 0;
  logic in_ready_o;
  logic [63:0] in_data = 0;
  logic out_valid_o;
  logic out_ready = 1;
  logic [63:0] out_data_o;
  logic out_last_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_coef [5];
  bit m_odd;
  int m_len;
  logic [15:0] pix [256];

  always #4 clk = ~clk;

  line_conv dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .in_valid_i(in_valid), .in_ready_o(in_ready_o),
    .in_data_i(in_data), .out_valid_o(out_valid_o), .out_ready_i(out_ready),
    .out_data_o(out_data_o), .out_last_o(out_last_o)
  );

  // vector: odd[35] set[34:33] stall[32] len[31:16] seed[15:0]
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 2'd0, 1'b0, 16'd16, 16'h0001},
    {1'b0, 2'd1, 1'b1, 16'd32, 16'h1d2f},
    {1'b1, 2'd2, 1'b0, 16'd12, 16'h7777},
    {1'b1, 2'd3, 1'b1, 16'd4,  16'h0abc},
    {1'b0, 2'd0, 1'b1, 16'd19, 16'hbeef},
    {1'b0, 2'd3, 1'b0, 16'd8,  16'hffff},
    {1'b1, 2'd1, 1'b1, 16'd20, 16'h4321},
    {1'b0, 2'd2, 1'b0, 16'd24, 16'h0f0f}
  };

  function automatic logic [15:0] coef_of(int set, int k);
    logic [15:0] t [5];
    case (set)
      0: t = '{16'h3000, 16'h1800, 16'h0800, 16'h0200, 16'h0080};
      1: t = '{16'h7fff, 16'hc000, 16'h2000, 16'hf000, 16'h0100};
      2: t = '{16'h0000, 16'h2800, 16'h1000, 16'h0400, 16'h0100};
      default: t = '{16'h1234, 16'h8000, 16'h7fff, 16'h0001, 16'hffff};
    endcase
    return t[k];
  endfunction

  function automatic longint xs(int i);
    int j;
    j = (i < 0) ? 0 : ((i >= m_len) ? m_len - 1 : i);
    return longint'(pix[j] >> 1);
  endfunction

  function automatic logic [15:0] model(int n);
    longint acc, s, p;
    acc = 0;
    for (int k = 0; k < 5; k++) begin
      if (k == 0) s = xs(n);
      else s = m_odd ? xs(n + k) - xs(n - k) : xs(n + k) + xs(n - k);
      p = s * longint'($signed(m_coef[k]));
      acc = acc + ((p + 64'sd16384) >>> 15);
    end
    return acc[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a <= 3'd4) m_coef[a] = d;
    else if (a == 3'd5) begin
      if ((d >> 2) != 0) m_len = int'(d & 16'hfffc);
    end else if (a == 3'd6) m_odd = d[0];
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 256; i++)
      pix[i] = 16'(seed * 31 + i * 40503 + i * i * 7) ^ 16'(seed << 3);
  endtask

  task automatic run_row(input bit stall, input bit mid_wr, input bit lat);
    int nb, sent, got, cyc, in1_cyc, out0_cyc, last_cyc;
    bit wr_done, last_ok;
    logic [63:0] exp_d;
    nb = m_len / 4; sent = 0; got = 0; cyc = 0;
    in1_cyc = -1; out0_cyc = -1; last_cyc = -1; wr_done = 0;
    while (got < nb && cyc < 4000) begin
      @(negedge clk);
      in_valid = (sent < nb) && !(stall && (cyc % 3 == 1));
      for (int l = 0; l < 4; l++) in_data[16*l +: 16] = (sent < nb) ? pix[4*sent+l] : 16'h0;
      out_ready = !(stall && (cyc % 5 >= 3));
      cfg_we = 0;
      if (mid_wr && !wr_done && sent >= 1) begin
        cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 16'h7123; wr_done = 1;
      end
      #1;
      if (lat && last_cyc >= 0 && cyc == last_cyc + 1)
        chk(in_ready_o == 1'b0, "R10 drain", 72'(in_ready_o), 72'(0));
      if (out_valid_o && out_ready) begin
        for (int l = 0; l < 4; l++) exp_d[16*l +: 16] = model(4*got + l);
        last_ok = (out_last_o == (got == nb - 1));
        // lanes: R1 R2 R3 R4 R5 R6; flag: R9
        chk(out_data_o == exp_d && last_ok, "R1 R2 R3 R4 R5 R6 R9 beat",
            {7'd0, out_last_o, out_data_o}, {7'd0, (got == nb - 1), exp_d});
        if (got == 0) out0_cyc = cyc;
        got++;
      end
      if (in_valid && in_ready_o) begin
        if (sent == 1) in1_cyc = cyc;
        if (sent == nb - 1) last_cyc = cyc;
        sent++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 0; out_ready = 1; cfg_we = 0;
    chk(got == nb, "R9 beat count", 72'(got), 72'(nb));
    if (lat && nb >= 2)
      chk(out0_cyc - in1_cyc == 3, "R13 latency", 72'(out0_cyc - in1_cyc), 72'(3));
  endtask

  task automatic load(input int set, input bit odd, input int len);
    for (int k = 0; k < 5; k++) cfg_write(3'(k), coef_of(set, k));
    cfg_write(3'd5, 16'(len));
    cfg_write(3'd6, {15'd0, odd});
  endtask

  initial begin
    for (int k = 0; k < 5; k++) m_coef[k] = 16'h0;
    m_odd = 0; m_len = 64;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    #1;
    chk(out_valid_o == 0 && in_ready_o == 1 && out_last_o == 0, "R12 reset ports",
        72'({out_valid_o, in_ready_o, out_last_o}), 72'(3'b010));

    // R12: default coefficients zero and length 64
    fill(7);
    run_row(0, 0, 1);

    for (int v = 0; v < 8; v++) begin
      load(int'(VEC[v][34:33]), VEC[v][35], int'(VEC[v][31:16]));
      fill(int'(VEC[v][15:0]));
      run_row(VEC[v][32], 0, !VEC[v][32]);
    end

    // R8: write during a row is ignored, now and for the next row
    load(0, 0, 16);
    fill(99);
    run_row(0, 1, 1);
    fill(100);
    run_row(0, 0, 1);

    // R7: zero length write ignored
    cfg_write(3'd5, 16'd3);
    fill(5);
    run_row(1, 0, 0);
    chk(m_len == 16, "R7 length kept", 72'(m_len), 72'(16));

    // R10: back-to-back rows with sharp edge change, odd mode
    load(2, 1, 8);
    for (int i = 0; i < 256; i++) pix[i] = 16'hfffe;
    run_row(0, 0, 1);
    for (int i = 0; i < 256; i++) pix[i] = 16'h0001;
    run_row(0, 0, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule